// File: doc/BRIEF.md
# Soft Mute Ramp and Zero-Run Detector

This block sits on the per-channel sample path, between the serial receiver and the modulator. On every sample strobe it scales the left and right words by a shared gain. While the mute request is held, the gain walks down toward bipolar zero by 0.5 dB per sample. Once the attenuation reaches a floor, both outputs are exactly zero. When the request drops, the gain walks back up by the same steps until it reaches unity.

Alongside the ramp, a run counter watches the incoming words. It raises a zero flag once a long unbroken run of all-zero samples has arrived. In normal stereo operation both channels must be zero. In filter-bypass mode, words arrive at the faster word rate on the left input alone, so only the left word is counted and the right input is ignored for detection.

Top module: `soft_mute_zero`

## Requirements
- R1: After reset, both outputs are 0, the output strobe is low, the zero flag is low, and the attenuation step index is 0 (unity gain).
- R2: With step index 0, each strobe yields `out_stb` high on the next clock, and each output equals its input sample unchanged. With no strobe, `out_stb` is low on the next clock.
- R3: While `mute_req` is high, each strobe raises the step index by one, until it reaches STEP_MAX. The output at step n is `(s * G[n mod 12]) >>> (16 + n/12)`, with an arithmetic shift that rounds toward minus infinity. Here `G[r] = round(65536 * 10^(-r/40))`: 0.5 dB per step, with each group of 12 steps taken as one binary halving.
- R4: A strobe that arrives while the step index equals STEP_MAX (default 240, i.e. -120 dB) produces exactly 0 on both outputs. The index stays at STEP_MAX while mute is held.
- R5: While `mute_req` is low, each strobe lowers a nonzero step index by one, until unity gain is reached.
- R6: The step index changes only on a strobe. Toggling `mute_req` between strobes has no effect on the next output.
- R7: The zero flag goes high after the strobe that completes ZERO_RUN (default 1024) consecutive zero samples. It is still low after ZERO_RUN-1 such samples.
- R8: Outside bypass mode, a strobe carrying a nonzero word on either channel clears the run count and drops the zero flag on the next clock.
- R9: With `bypass` high, only the left word takes part in zero detection. A nonzero right word neither resets the count nor clears a raised flag.
- R10: Both channels are scaled by the same step index on every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | One-cycle pulse marking a valid sample pair |
| smp_l_i | input | W | Left sample, two's complement |
| smp_r_i | input | W | Right sample, two's complement |
| mute_req | input | 1 | High requests ramp to zero |
| bypass | input | 1 | Filter-bypass mode: zero detection uses left word only |
| out_stb | output | 1 | Pulses one clock after each input strobe |
| out_l | output | W | Attenuated left sample |
| out_r | output | W | Attenuated right sample |
| zero_flag | output | 1 | High after a full run of zero samples |

## Verification
The assertions check the following rules on every cycle: the step index moves by exactly one per strobe in the commanded direction and holds between strobes; the floor forces zero; unity gain passes samples unchanged; the output strobe follows the input strobe; and a nonzero left word always clears the flag. Only the bench scenarios can show that the gain at each intermediate step has the right value, because the bench builds its own gain curve from the decibel formula. The same holds for the exact strobe on which the zero flag rises after a full run, and for the rule that a nonzero right word is ignored in bypass mode.

// File: rtl/soft_mute_zero.sv
module soft_mute_zero #(
  parameter int W        = 24,
  parameter int STEP_MAX = 240,
  parameter int ZERO_RUN = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_stb,
  input  logic signed [W-1:0] smp_l_i,
  input  logic signed [W-1:0] smp_r_i,
  input  logic                mute_req,
  input  logic                bypass,
  output logic                out_stb,
  output logic signed [W-1:0] out_l,
  output logic signed [W-1:0] out_r,
  output logic                zero_flag
);
  localparam int IW = $clog2(STEP_MAX + 1);
  localparam int CW = $clog2(ZERO_RUN + 1);
  localparam int PW = W + 18;
  localparam int SW = $clog2(STEP_MAX / 12 + 17) + 1;

  logic [IW-1:0] idx;
  logic [CW-1:0] zrun;
  logic [16:0]   gain;
  logic [3:0]    frac;
  logic [SW-1:0] sh;
  logic          at_floor, words_zero;
  logic signed [PW-1:0] prod_l, prod_r;

  function automatic logic [16:0] gain_of(input logic [3:0] r);
    case (r)
      4'd0:    return 17'd65536;
      4'd1:    return 17'd61870;
      4'd2:    return 17'd58409;
      4'd3:    return 17'd55142;
      4'd4:    return 17'd52057;
      4'd5:    return 17'd49145;
      4'd6:    return 17'd46396;
      4'd7:    return 17'd43801;
      4'd8:    return 17'd41350;
      4'd9:    return 17'd39037;
      4'd10:   return 17'd36854;
      default: return 17'd34792;
    endcase
  endfunction

  assign at_floor   = (idx == IW'(STEP_MAX));
  assign frac       = 4'(idx % IW'(12));
  assign sh         = SW'(16) + SW'(idx / IW'(12));
  assign gain       = gain_of(frac);
  assign prod_l     = $signed(smp_l_i) * $signed({1'b0, gain});
  assign prod_r     = $signed(smp_r_i) * $signed({1'b0, gain});
  assign words_zero = bypass ? (smp_l_i == '0) : (smp_l_i == '0 && smp_r_i == '0);
  assign zero_flag  = (zrun == CW'(ZERO_RUN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx     <= '0;
      zrun    <= '0;
      out_stb <= 1'b0;
      out_l   <= '0;
      out_r   <= '0;
    end else begin
      out_stb <= smp_stb;
      if (smp_stb) begin
        out_l <= at_floor ? '0 : W'(prod_l >>> sh);
        out_r <= at_floor ? '0 : W'(prod_r >>> sh);
        if (mute_req && !at_floor)     idx <= idx + 1'b1;
        else if (!mute_req && idx != 0) idx <= idx - 1'b1;
        if (!words_zero)    zrun <= '0;
        else if (!zero_flag) zrun <= zrun + 1'b1;
      end
    end
  end

  // R6
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(idx));
  // R3
  mute_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && mute_req && !at_floor |=> idx == $past(idx) + 1'b1);
  // R5
  unmute_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && !mute_req && idx != 0 |=> idx == $past(idx) - 1'b1);
  // R4
  floor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && at_floor |=> out_l == 0 && out_r == 0);
  // R2
  unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && idx == 0 |=> out_l == $past(smp_l_i) && out_r == $past(smp_r_i));
  // R2
  stb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> out_stb);
  // R2
  stb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> !out_stb);
  // R8
  zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && smp_l_i != 0 |=> !zero_flag);
endmodule

// File: tb/soft_mute_zero_test.sv
module soft_mute_zero_test;
  localparam int W = 24, STEP_MAX = 240, ZERO_RUN = 1024;

  logic clk = 0, rst_n = 0, stb = 0, mute = 0, byp = 0;
  logic signed [W-1:0] sl = 0, sr = 0;
  logic out_stb, zero_flag;
  logic signed [W-1:0] out_l, out_r;

  always #2.5 clk = ~clk;

  soft_mute_zero #(.W(W), .STEP_MAX(STEP_MAX), .ZERO_RUN(ZERO_RUN)) uut (
    .clk(clk), .rst_n(rst_n), .smp_stb(stb), .smp_l_i(sl), .smp_r_i(sr),
    .mute_req(mute), .bypass(byp), .out_stb(out_stb), .out_l(out_l),
    .out_r(out_r), .zero_flag(zero_flag));

  typedef struct {
    logic signed [W-1:0] l;
    logic signed [W-1:0] r;
    logic f;
    string tag;
  } item_t;
  item_t q[$];

  int tests = 0, fails = 0;
  int m_idx = 0, m_run = 0;
  int unsigned seed = 32'h1234_5678;

  function automatic logic signed [W-1:0] att(input logic signed [W-1:0] s, input int n);
    longint g, p;
    if (n >= STEP_MAX) return '0;
    g = longint'($rtoi($pow(10.0, -(n % 12) / 40.0) * 65536.0 + 0.5));
    p = longint'(s) * g;
    p = p >>> (16 + n / 12);
    return W'(p);
  endfunction

  function automatic logic [W-1:0] rnd();
    seed = seed * 1103515245 + 12345;
    return seed[30:7];
  endfunction

  task automatic send(input logic signed [W-1:0] l, input logic signed [W-1:0] r,
                      input logic m, input logic b, input string tag, input int gap);
    item_t e;
    @(negedge clk);
    stb = 1; sl = l; sr = r; mute = m; byp = b;
    e.l = att(l, m_idx);
    e.r = att(r, m_idx);
    if (m && m_idx < STEP_MAX) m_idx++;
    else if (!m && m_idx > 0) m_idx--;
    if (b ? (l == 0) : (l == 0 && r == 0)) begin
      if (m_run < ZERO_RUN) m_run++;
    end else m_run = 0;
    e.f = (m_run == ZERO_RUN);
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    stb = 0;
    repeat (gap) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_stb) begin
      item_t e;
      tests++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL %s: output strobe with no pending sample (actual out_stb=1, expected 0)", "R2");
      end else begin
        e = q.pop_front();
        if (out_l !== e.l || out_r !== e.r || zero_flag !== e.f) begin
          fails++;
          $display("FAIL %s: actual l=%0d r=%0d flag=%0b, expected l=%0d r=%0d flag=%0b",
                   e.tag, out_l, out_r, zero_flag, e.l, e.r, e.f);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    tests++;
    if (out_l !== 0 || out_r !== 0 || out_stb !== 0 || zero_flag !== 0) begin
      fails++;
      $display("FAIL R1: actual l=%0d r=%0d stb=%0b flag=%0b, expected all 0",
               out_l, out_r, out_stb, zero_flag);
    end
    rst_n = 1;
    // R2: unity pass-through
    send(24'sh7FFFFF, -24'sh800000, 0, 0, "R2", 0);
    send(1, -1, 0, 0, "R2", 1);
    send(0, 24'sh123456, 0, 0, "R2", 0);
    for (int i = 0; i < 5; i++) send(rnd(), rnd(), 0, 0, "R2", i % 2);
    // R3 / R4 / R10: mute ramp down to floor and hold
    for (int i = 0; i < 250; i++) begin
      v = rnd();
      if (i % 7 == 0) send(v, v, 1, 0, "R10", 0);
      else if (i % 50 == 1) send(24'sh7FFFFF, -24'sh800000, 1, 0, i < STEP_MAX ? "R3" : "R4", 0);
      else send(v, rnd(), 1, 0, i < STEP_MAX ? "R3" : "R4", (i % 3 == 0) ? 2 : 0);
    end
    // R6: mute toggled between strobes changes nothing
    @(negedge clk); mute = 0;
    repeat (5) @(negedge clk);
    send(24'sh400000, 24'sh400000, 1, 0, "R6", 0);
    for (int i = 0; i < 20; i++) send(rnd(), rnd(), 0, 0, "R5", 0);
    @(negedge clk); mute = 1;
    repeat (4) @(negedge clk);
    @(negedge clk); mute = 0;
    send(24'sh3FFFFF, -24'sh3FFFFF, 0, 0, "R6", 0);
    // R5: ramp back to unity
    for (int i = 0; i < 240; i++) send(rnd(), rnd(), 0, 0, "R5", i % 2);
    send(24'sh55AA55, 24'sh2AA5AA, 0, 0, "R5", 0);
    // R7: zero run
    for (int i = 0; i < ZERO_RUN - 1; i++) send(0, 0, 0, 0, "R7", 0);
    send(0, 0, 0, 0, "R7", 0);
    send(0, 0, 0, 0, "R7", 0);
    // R8: nonzero on either channel clears
    send(0, 5, 0, 0, "R8", 0);
    for (int i = 0; i < 4; i++) send(0, 0, 0, 0, "R8", 0);
    send(-3, 0, 0, 0, "R8", 0);
    // R9: bypass ignores right word
    for (int i = 0; i < ZERO_RUN; i++) send(0, rnd() | 24'd1, 0, 1, "R9", 0);
    send(0, 7, 0, 1, "R9", 0);
    send(0, -24'sh100000, 0, 1, "R9", 0);
    send(0, 7, 0, 0, "R8", 0);
    repeat (4) @(negedge clk);
    tests++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R2: actual %0d samples without output, expected 0", q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule